// File: doc/BRIEF.md
# Serial Port FIFO Control with Receive Trigger

This block holds the receive and transmit character queues of a 16550-style serial port, together with the write-only control register that governs them. Software writes the control register over a small bus port. The bits of that register empty either queue on command, choose how many received bytes must accumulate before an interrupt request is raised, and select which of two signalling schemes the active-low receive-ready and transmit-ready pins follow. The queue enable bit reads as permanently set.

The receive side is filled by the line receiver one character at a time and drained by the host. The transmit side is filled by the host and drained by the line transmitter. Each side reports its occupancy and the last character it delivered, and keeps a sticky flag for characters lost to a full queue. Serialization, baud timing and interrupt identification are handled elsewhere.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset both counts are 0, both delivered-data outputs are 0, both overrun flags are 0, the receive trigger is 1 byte, the pin scheme is mode 0, `rx_irq` is 0, `rxrdy_n` is 1 and `txrdy_n` is 0.
- R2: The control register is written only when `bus_wr` is 1 and `bus_addr` equals 2. A write to any other address changes no output and no later behaviour.
- R3: A control write with bit 1 set empties the receive queue and clears its overrun flag. With bit 2 set it does the same for the transmit queue. Both take effect at the same clock edge as the write and win over a push at that edge. The clear bits are not stored, so a later write without them clears nothing.
- R4: Bits 0, 4 and 5 of the control byte have no effect. Writing 0 to bit 0 still leaves the queues working and the mode selection in force.
- R5: The trigger field is {bit 7, bit 6}. 2'b00 gives 1 byte, 2'b10 gives 4 bytes, 2'b01 gives 8 bytes and 2'b11 gives 8 bytes. The field is held until the next control write.
- R6: `rx_irq` is 1 exactly while receive occupancy is at or above the selected trigger level.
- R7: In mode 0 (bit 3 written 0), `rxrdy_n` is 0 while the receive queue holds at least one byte, and `txrdy_n` is 0 while the transmit queue is empty.
- R8: In mode 1 (bit 3 written 1), `rxrdy_n` is 0 while receive occupancy is at or above the trigger level, and `txrdy_n` is 0 while the transmit queue is not full (fewer than 16 entries).
- R9: Each queue is 16 entries deep and first-in first-out. A successful pop presents the oldest byte on the data output from the next clock edge. A push and a pop at the same edge are both accepted, even when the queue is full.
- R10: A push to a full queue with no pop at that edge is dropped. The count stays at 16 and that queue's overrun flag sets and stays set until that queue is cleared.
- R11: A pop from an empty queue leaves the count at 0 and the data output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| rx_push | input | 1 | Receiver delivers a character |
| rx_din | input | 8 | Received character |
| rx_pop | input | 1 | Host takes a received character |
| rx_dout | output | 8 | Last character taken from the receive queue |
| rx_count | output | 5 | Receive queue occupancy |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| tx_push | input | 1 | Host writes a character to send |
| tx_din | input | 8 | Character to send |
| tx_pop | input | 1 | Transmitter takes a character |
| tx_dout | output | 8 | Last character taken from the transmit queue |
| tx_count | output | 5 | Transmit queue occupancy |
| tx_overrun | output | 1 | Sticky transmit overrun flag |
| rx_irq | output | 1 | Receive trigger interrupt request |
| rxrdy_n | output | 1 | Active-low receive ready pin |
| txrdy_n | output | 1 | Active-low transmit ready pin |

## Verification
Directed sequences fill each queue to exactly 16 and then push once more, pop an empty queue, and write control bytes with only bits 0, 4 and 5 set, or to wrong addresses. These separate drop and overrun handling and ignored writes from the clear path. The receive queue is walked through every count from 0 to 9 under each trigger code, in both pin modes, which tells the 4-byte level apart from the two 8-byte codes and the mode 0 pin rule apart from the mode 1 rule. Random phases that bias toward filling, draining, or simultaneous push and pop, with occasional random control writes, exercise wrap-around and push-with-pop at full. A bench model of both queues is compared against every output on every cycle.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
  localparam int CTRL_ADDR   = 2;
  localparam int BIT_RX_CLR  = 1;
  localparam int BIT_TX_CLR  = 2;
  localparam int BIT_MODE    = 3;
  localparam int BIT_TRIG_LO = 6;
  localparam int BIT_TRIG_HI = 7;

  // trigger field is {bit7, bit6}
  typedef enum logic [1:0] {
    TRIG_ONE   = 2'b00,
    TRIG_EIGHT = 2'b01,
    TRIG_FOUR  = 2'b10,
    TRIG_EIGHT_ALT = 2'b11
  } trig_code_e;

  function automatic int unsigned trig_bytes(trig_code_e code);
    case (code)
      TRIG_ONE:  return 1;
      TRIG_FOUR: return 4;
      default:   return 8;
    endcase
  endfunction

  function automatic logic level_reached(int unsigned occ, trig_code_e code);
    return occ >= trig_bytes(code);
  endfunction
endpackage

// File: rtl/ufc_ctrl_reg.sv
module ufc_ctrl_reg
  import ufc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rx_clr,
  output logic              tx_clr,
  output trig_code_e        trig_code,
  output logic              dma_mode
);
  // queue enable always behaves as set
  localparam logic QUEUE_EN = 1'b1;

  logic       hit;
  logic       mode_q;
  trig_code_e trig_q;

  assign hit    = wr_en && (addr == ADDR_W'(CTRL_ADDR));
  assign rx_clr = hit && wdata[BIT_RX_CLR];
  assign tx_clr = hit && wdata[BIT_TX_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      trig_q <= TRIG_ONE;
    end else if (hit) begin
      mode_q <= wdata[BIT_MODE];
      trig_q <= trig_code_e'({wdata[BIT_TRIG_HI], wdata[BIT_TRIG_LO]});
    end
  end

  assign trig_code = trig_q;
  assign dma_mode  = mode_q & QUEUE_EN;

  // R2: fields change only on a decoded write
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(trig_q) && $stable(mode_q));
endmodule

// File: rtl/ufc_sync_fifo.sv
module ufc_sync_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [CNT_W-1:0]  count,
  output logic              overrun,
  output logic              push_drop,
  output logic              pop_empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q;
  logic              full, empty, do_pop, do_push;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign do_pop    = !clr && pop && !empty;
  assign do_push   = !clr && push && (!full || do_pop);
  assign push_drop = !clr && push && full && !do_pop;
  assign pop_empty = !clr && pop && empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt_q   <= '0;
      dout    <= '0;
      overrun <= 1'b0;
    end else if (clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt_q   <= '0;
      overrun <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop) begin
        rd_ptr <= ptr_next(rd_ptr);
        dout   <= mem[rd_ptr];
      end
      if (do_push && !do_pop) cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      if (push_drop) overrun <= 1'b1;
    end
  end

  assign count = cnt_q;

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r10_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> overrun && (cnt_q == CNT_W'(DEPTH)));
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pop_empty && !push |=> $stable(dout) && (cnt_q == '0));
  a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !overrun);
endmodule

// File: rtl/ufc_ready_logic.sv
module ufc_ready_logic
  import ufc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  trig_code_e       trig_code,
  input  logic             dma_mode,
  output logic             rx_irq,
  output logic             rxrdy_n,
  output logic             txrdy_n
);
  logic rx_at_level, rx_any, tx_none, tx_room;

  always_comb begin
    rx_at_level = level_reached(int'(rx_count), trig_code);
    rx_any      = (rx_count != '0);
    tx_none     = (tx_count == '0);
    tx_room     = (tx_count < CNT_W'(DEPTH));
  end

  assign rx_irq  = rx_at_level;
  assign rxrdy_n = dma_mode ? !rx_at_level : !rx_any;
  assign txrdy_n = dma_mode ? !tx_room     : !tx_none;

  a_r6_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_count != '0);
  a_r7_mode0_tx_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_mode && tx_count != '0) |-> txrdy_n);
  a_r8_mode1_rx_follows_irq: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode |-> (rxrdy_n == !rx_irq));
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import ufc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_din,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_dout,
  output logic [CNT_W-1:0]  rx_count,
  output logic              rx_overrun,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_din,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_dout,
  output logic [CNT_W-1:0]  tx_count,
  output logic              tx_overrun,
  output logic              rx_irq,
  output logic              rxrdy_n,
  output logic              txrdy_n
);
  logic       rx_clr, tx_clr, dma_mode;
  trig_code_e trig_code;
  logic       rx_drop, tx_drop, rx_pop_empty, tx_pop_empty;

  ufc_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(8)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rx_clr(rx_clr), .tx_clr(tx_clr), .trig_code(trig_code), .dma_mode(dma_mode)
  );

  ufc_sync_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .din(rx_din),
    .pop(rx_pop), .dout(rx_dout), .count(rx_count), .overrun(rx_overrun),
    .push_drop(rx_drop), .pop_empty(rx_pop_empty)
  );

  ufc_sync_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .din(tx_din),
    .pop(tx_pop), .dout(tx_dout), .count(tx_count), .overrun(tx_overrun),
    .push_drop(tx_drop), .pop_empty(tx_pop_empty)
  );

  ufc_ready_logic #(.DEPTH(DEPTH)) u_ready (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .trig_code(trig_code), .dma_mode(dma_mode),
    .rx_irq(rx_irq), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
  );

  // R3: the clear of one queue leaves the other's count untouched
  a_r3_rx_clear_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr && !tx_clr && !tx_push && !tx_pop) |=> $stable(tx_count));
  a_r3_tx_clear_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clr && !rx_clr && !rx_push && !rx_pop) |=> $stable(rx_count));
  a_r10_rx_drop_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !rx_clr) |=> rx_overrun);
  a_r11_tx_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop_empty && !tx_push) |=> $stable(tx_dout));
  a_r10_tx_drop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> tx_overrun);
  a_r11_rx_empty_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop_empty && !rx_push) |=> rx_count == '0);
endmodule

// File: tb/uart_fifo_ctrl_bench.sv
module uart_fifo_ctrl_bench;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0] rx_din = '0, tx_din = '0;
  logic [7:0] rx_dout, tx_dout;
  logic [4:0] rx_count, tx_count;
  logic       rx_overrun, tx_overrun, rx_irq, rxrdy_n, txrdy_n;

  int checks = 0;
  int errors = 0;

  uart_fifo_ctrl u_uart_fifo_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
    .rx_count(rx_count), .rx_overrun(rx_overrun),
    .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
    .tx_count(tx_count), .tx_overrun(tx_overrun),
    .rx_irq(rx_irq), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
  );

  always #5 clk = ~clk;

  // reference model
  logic [7:0] mrx[$];
  logic [7:0] mtx[$];
  logic [7:0] m_rx_dout = 0, m_tx_dout = 0;
  logic       m_rx_ovr = 0, m_tx_ovr = 0, m_mode = 0;
  logic [1:0] m_trig = 2'b00;

  function automatic int level_of(logic [1:0] code);
    if (code == 2'b00) return 1;
    else if (code == 2'b10) return 4;
    return 8;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    int lvl = level_of(m_trig);
    int rc = mrx.size();
    int tc = mtx.size();
    chk("R9", "rx_count", int'(rx_count), rc);
    chk("R9", "tx_count", int'(tx_count), tc);
    chk("R9", "rx_dout", int'(rx_dout), int'(m_rx_dout));
    chk("R9", "tx_dout", int'(tx_dout), int'(m_tx_dout));
    chk("R10", "rx_overrun", int'(rx_overrun), int'(m_rx_ovr));
    chk("R10", "tx_overrun", int'(tx_overrun), int'(m_tx_ovr));
    chk("R6", "rx_irq", int'(rx_irq), int'(rc >= lvl));
    if (m_mode) begin
      chk("R8", "rxrdy_n", int'(rxrdy_n), int'(!(rc >= lvl)));
      chk("R8", "txrdy_n", int'(txrdy_n), int'(!(tc < DEPTH)));
    end else begin
      chk("R7", "rxrdy_n", int'(rxrdy_n), int'(rc == 0));
      chk("R7", "txrdy_n", int'(txrdy_n), int'(tc != 0));
    end
  endtask

  task automatic model_queue(ref logic [7:0] q[$], ref logic [7:0] dout, ref logic ovr,
                             input logic clr, input logic push, input logic [7:0] din,
                             input logic pop);
    logic popok;
    if (clr) begin
      q.delete();
      ovr = 0;
    end else begin
      popok = pop && q.size() > 0;
      if (popok) dout = q.pop_front();
      if (push) begin
        if (q.size() < DEPTH) q.push_back(din);
        else ovr = 1;
      end
    end
  endtask

  // one clock: inputs already driven; wait edge, update model, check at negedge
  task automatic step();
    logic hit;
    hit = bus_wr && bus_addr == 3'd2;
    @(posedge clk);
    model_queue(mrx, m_rx_dout, m_rx_ovr, hit && bus_wdata[1], rx_push, rx_din, rx_pop);
    model_queue(mtx, m_tx_dout, m_tx_ovr, hit && bus_wdata[2], tx_push, tx_din, tx_pop);
    if (hit) begin
      m_mode = bus_wdata[3];
      m_trig = {bus_wdata[7], bus_wdata[6]};
    end
    @(negedge clk);
    check_all();
    bus_wr = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
  endtask

  task automatic push_rx(logic [7:0] d);
    rx_push = 1; rx_din = d;
    step();
  endtask

  task automatic push_tx(logic [7:0] d);
    tx_push = 1; tx_din = d;
    step();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int seed = 32'h5eed_0a17;
    void'($urandom(seed));
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "rx_count", int'(rx_count), 0);
    chk("R1", "tx_count", int'(tx_count), 0);
    chk("R1", "rx_irq", int'(rx_irq), 0);
    chk("R1", "rxrdy_n", int'(rxrdy_n), 1);
    chk("R1", "txrdy_n", int'(txrdy_n), 0);
    chk("R1", "overruns", int'({rx_overrun, tx_overrun}), 0);

    // R9/R10: fill receive queue, then overflow
    for (int i = 0; i < DEPTH; i++) push_rx(8'(i + 8'h30));
    push_rx(8'hEE);
    chk("R10", "rx full count", int'(rx_count), 16);
    chk("R10", "rx overrun set", int'(rx_overrun), 1);
    // R9: push with pop when full
    rx_push = 1; rx_din = 8'h99; rx_pop = 1; step();
    chk("R9", "rx first out", int'(rx_dout), 8'h30);
    // R2: wrong address writes with clear bits ignored
    wr(3'd3, 8'hFF);
    wr(3'd0, 8'h06);
    chk("R2", "rx kept", int'(rx_count), 16);
    // R4: reserved bits only, bit0 zero, mode 1 selected via bit3
    wr(3'd2, 8'h38);
    chk("R4", "rx kept after reserved", int'(rx_count), 16);
    chk("R4", "mode1 txrdy_n", int'(txrdy_n), 0);
    // R3: clear receive, overrun cleared
    wr(3'd2, 8'h02);
    chk("R3", "rx cleared", int'(rx_count), 0);
    chk("R3", "rx overrun cleared", int'(rx_overrun), 0);
    // R11: pop empty keeps last value
    rx_pop = 1; step();
    chk("R11", "rx_dout held", int'(rx_dout), 8'h30);

    // R5/R6/R7/R8: trigger walk in both modes
    for (int mode = 0; mode < 2; mode++) begin
      for (int code = 0; code < 4; code++) begin
        wr(3'd2, {2'(code), 2'b00, 1'(mode), 3'b010});
        for (int n = 0; n < 9; n++) begin
          chk("R5", "irq vs level", int'(rx_irq), int'(n >= level_of(2'(code))));
          push_rx(8'(n));
        end
      end
    end
    // R3: clear bit not stored
    wr(3'd2, 8'h00);
    chk("R3", "no stored clear", int'(rx_count), 9);

    // R8/R10: transmit fill in mode 1
    wr(3'd2, 8'h0C);
    for (int i = 0; i < DEPTH; i++) push_tx(8'(i + 8'h50));
    chk("R8", "tx full pin", int'(txrdy_n), 1);
    push_tx(8'h11);
    chk("R10", "tx overrun", int'(tx_overrun), 1);
    tx_pop = 1; step();
    chk("R9", "tx first out", int'(tx_dout), 8'h50);

    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      int bias = ph % 3;
      for (int c = 0; c < 100; c++) begin
        int r = $urandom_range(0, 99);
        rx_din = 8'($urandom); tx_din = 8'($urandom);
        rx_push = (bias == 0) ? (r < 70) : (bias == 1) ? (r < 20) : (r < 50);
        rx_pop  = (bias == 0) ? ($urandom_range(0, 99) < 20) : (bias == 1) ? ($urandom_range(0, 99) < 70) : ($urandom_range(0, 99) < 50);
        tx_push = (bias == 0) ? ($urandom_range(0, 99) < 70) : ($urandom_range(0, 99) < 30);
        tx_pop  = (bias == 1) ? ($urandom_range(0, 99) < 70) : ($urandom_range(0, 99) < 25);
        if ($urandom_range(0, 99) < 3) begin
          bus_wr = 1;
          bus_addr = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd2;
          bus_wdata = 8'($urandom);
          if ($urandom_range(0, 3) != 0) bus_wdata[2:1] = 2'b00;
        end
        step();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule